// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the shared control and status front end of a small SD host subsystem holding one or two slot controllers. It decodes a 4 KiB window of 32-bit register accesses. The lowest 256 bytes hold the wrapper's own words: a slot-presence and reset-request word, a debounce setting, a bus setting, write-protect polarity, card-detect, and a read-only interrupt status word. Every other word in that range is plain storage. The same range also carries, at fixed offsets, each slot's capability word and maximum-current word. Those words are held here and driven out to the slots.

Accesses to the 256-byte page that follows belong to slot 0, and the page after that belongs to slot 1. Such an access is forwarded to the slot as a one-cycle strobe with an 8-bit local address, and it completes when the slot returns ready. Each slot's interrupt level is registered into the status word. A single interrupt output is raised while any status bit is set. An access that is not a full aligned word, or that falls outside every mapped page, returns zero, changes nothing and sets a sticky error flag.

Top module: `sd_wrap_regs`

## Requirements
- R1: After reset, word 0x00 reads with bit 16+i set for each configured slot i and all other bits clear. Word 0x04 reads 0x00000005. Words 0x08, 0xEC, 0xF0 and 0xFC read 0. The error flag and the interrupt output are low.
- R2: A write to word 0x00 stores the written value with bit 0 forced to 0, so bit 0 always reads back as 0.
- R3: Every other word in 0x00–0xFC, apart from 0xFC and the slot capability words, reads back the last value written to it.
- R4: Words 0x10 and 0x18 hold slot 0's capability and max-current words, and 0x20 and 0x28 hold slot 1's. Each reads back what was written, drives its slot's output lane, and resets to CAP_RESET (capability) or 0 (max-current).
- R5: Bit n of word 0xFC equals slot n's interrupt input as sampled at the previous clock edge. The interrupt output is the OR of those bits.
- R6: Writes to word 0xFC have no effect.
- R7: An access whose byte enables are not 4'hF, or whose address bits [1:0] are not 0, is acknowledged with read data 0. It stores nothing, reaches no slot, and sets the error flag.
- R8: An access whose address bits [11:8] exceed the slot count is acknowledged with data 0 and is ignored. It sets the error flag, which stays set until reset.
- R9: An access with address bits [11:8] = i+1 raises bit i of the slot strobe for exactly one cycle, the cycle after the request. The strobe carries address bits [7:0], the write flag and the write data. The access is acknowledged one cycle after that slot's ready is sampled high, and a read returns that slot's read data.
- R10: Accesses to word offsets in 0x000–0x0FF, and rejected accesses, are acknowledged in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle, accepted when no slot access is pending |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address in the window |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access completed |
| rdata_o | output | 32 | Read data, valid with ack_o |
| slot_req_o | output | NUM_SLOTS | One-cycle strobe per slot |
| slot_we_o | output | 1 | Write flag of the forwarded access |
| slot_addr_o | output | 8 | Slot-local byte address |
| slot_wdata_o | output | 32 | Forwarded write data |
| slot_rdata_i | input | 32*NUM_SLOTS | Slot read data, lane i for slot i |
| slot_ready_i | input | NUM_SLOTS | Slot completed the forwarded access |
| slot_irq_i | input | NUM_SLOTS | Slot interrupt levels |
| slot_cap_o | output | 32*NUM_SLOTS | Capability word per slot |
| slot_maxcurr_o | output | 32*NUM_SLOTS | Max-current word per slot |
| irq_o | output | 1 | Combined interrupt |
| err_o | output | 1 | Sticky access-error flag |

## Verification
The main instance is built with NUM_SLOTS = 2. This puts both capability pairs, both slot pages and the presence bits 16 and 17 within reach. The bench sweeps all 64 word offsets of the global page, all four interrupt combinations and every rejected byte-enable pattern. A second instance with NUM_SLOTS = 1 shows the one-slot reset value of word 0x00. It also shows that page 0x200, which is a slot page in the main build, is out of range there.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned WIN_AW   = 12;
  localparam int unsigned LOC_AW   = 8;
  localparam int unsigned NUM_WORDS = 64;
  localparam int unsigned WIDX_W   = 6;

  localparam logic [WIDX_W-1:0] W_INFO = 6'h00;
  localparam logic [WIDX_W-1:0] W_DEB  = 6'h01;
  localparam logic [WIDX_W-1:0] W_IRQ  = 6'h3F;
  localparam int unsigned W_CAP0   = 4;   // byte 0x10
  localparam int unsigned W_MCUR0  = 6;   // byte 0x18
  localparam int unsigned W_STRIDE = 4;   // 0x10 bytes per slot

  localparam logic [DW-1:0] DEB_RESET = 32'h0000_0005;
  localparam int unsigned PRESENT_LSB = 16;

  typedef enum logic [1:0] {ACC_GLOBAL, ACC_SLOT, ACC_BAD} acc_e;

  function automatic logic [DW-1:0] info_reset(int unsigned n);
    logic [DW-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < n; i++) v[PRESENT_LSB+i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
  import sdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [3:0]        be_i,
  output acc_e              kind_o,
  output logic [SIDX_W-1:0] slot_idx_o
);
  logic [3:0] page;
  assign page = addr_i[11:8];

  always_comb begin
    kind_o     = ACC_BAD;
    slot_idx_o = '0;
    if (be_i == 4'hF && addr_i[1:0] == 2'b00) begin
      if (page == 4'd0) begin
        kind_o = ACC_GLOBAL;
      end else if (page <= 4'(NUM_SLOTS)) begin
        kind_o     = ACC_SLOT;
        slot_idx_o = SIDX_W'(page - 4'd1);
      end
    end
  end
endmodule

// File: rtl/sdw_irq_fold.sv
module sdw_irq_fold #(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] irq_i,
  output logic [NUM_SLOTS-1:0] stat_o,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= irq_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/sdw_slot_bridge.sv
module sdw_slot_bridge
  import sdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [SIDX_W-1:0]       idx_i,
  input  logic                    we_i,
  input  logic [LOC_AW-1:0]       addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NUM_SLOTS-1:0]    slot_req_o,
  output logic                    slot_we_o,
  output logic [LOC_AW-1:0]       slot_addr_o,
  output logic [DW-1:0]           slot_wdata_o,
  input  logic [NUM_SLOTS*DW-1:0] slot_rdata_i,
  input  logic [NUM_SLOTS-1:0]    slot_ready_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DW-1:0]           rdata_o
);
  typedef enum logic {BR_IDLE, BR_WAIT} br_e;

  br_e                  state_q;
  logic [SIDX_W-1:0]    idx_q;
  logic [NUM_SLOTS-1:0] req_q;
  logic                 we_q;
  logic [LOC_AW-1:0]    addr_q;
  logic [DW-1:0]        wdata_q;
  logic                 done_q;
  logic [DW-1:0]        rdata_q;
  logic [DW-1:0]        lane [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
    assign lane[g] = slot_rdata_i[g*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BR_IDLE;
      idx_q   <= '0;
      req_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      req_q  <= '0;
      done_q <= 1'b0;
      if (state_q == BR_IDLE) begin
        if (start_i) begin
          state_q <= BR_WAIT;
          idx_q   <= idx_i;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          for (int i = 0; i < NUM_SLOTS; i++) req_q[i] <= (idx_i == SIDX_W'(i));
        end
      end else if (slot_ready_i[idx_q]) begin
        state_q <= BR_IDLE;
        done_q  <= 1'b1;
        rdata_q <= lane[idx_q];
      end
    end
  end

  assign slot_req_o   = req_q;
  assign slot_we_o    = we_q;
  assign slot_addr_o  = addr_q;
  assign slot_wdata_o = wdata_q;
  assign busy_o       = (state_q == BR_WAIT);
  assign done_o       = done_q;
  assign rdata_o      = rdata_q;
endmodule

// File: rtl/sd_wrap_regs.sv
module sd_wrap_regs
  import sdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter logic [31:0] CAP_RESET = 32'h0158_30B0,
  localparam int unsigned SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [11:0]             addr_i,
  input  logic [3:0]              be_i,
  input  logic [31:0]             wdata_i,
  output logic                    ack_o,
  output logic [31:0]             rdata_o,
  output logic [NUM_SLOTS-1:0]    slot_req_o,
  output logic                    slot_we_o,
  output logic [7:0]              slot_addr_o,
  output logic [31:0]             slot_wdata_o,
  input  logic [NUM_SLOTS*32-1:0] slot_rdata_i,
  input  logic [NUM_SLOTS-1:0]    slot_ready_i,
  input  logic [NUM_SLOTS-1:0]    slot_irq_i,
  output logic [NUM_SLOTS*32-1:0] slot_cap_o,
  output logic [NUM_SLOTS*32-1:0] slot_maxcurr_o,
  output logic                    irq_o,
  output logic                    err_o
);
  localparam logic [DW-1:0] INFO_RESET = info_reset(NUM_SLOTS);

  acc_e                 kind;
  logic [SIDX_W-1:0]    dec_idx;
  logic                 br_busy, br_done;
  logic [DW-1:0]        br_rdata;
  logic [NUM_SLOTS-1:0] irq_stat;
  logic                 accept;
  logic [WIDX_W-1:0]    widx;

  logic [DW-1:0]        regs_q [NUM_WORDS];
  logic [DW-1:0]        cap_q  [NUM_SLOTS];
  logic [DW-1:0]        mcur_q [NUM_SLOTS];
  logic                 cap_hit, mcur_hit;
  logic [SIDX_W-1:0]    cap_sel, mcur_sel;
  logic [DW-1:0]        rd_val;
  logic                 ack_q, err_q;
  logic [DW-1:0]        rdata_q;
  logic                 gwr;

  sdw_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr_i     (addr_i),
    .be_i       (be_i),
    .kind_o     (kind),
    .slot_idx_o (dec_idx)
  );

  sdw_irq_fold #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (slot_irq_i),
    .stat_o (irq_stat),
    .irq_o  (irq_o)
  );

  assign accept = req_i & ~br_busy;
  assign widx   = addr_i[7:2];
  assign gwr    = accept && kind == ACC_GLOBAL && we_i;

  sdw_slot_bridge #(.NUM_SLOTS(NUM_SLOTS)) u_br (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept && kind == ACC_SLOT),
    .idx_i        (dec_idx),
    .we_i         (we_i),
    .addr_i       (addr_i[7:0]),
    .wdata_i      (wdata_i),
    .slot_req_o   (slot_req_o),
    .slot_we_o    (slot_we_o),
    .slot_addr_o  (slot_addr_o),
    .slot_wdata_o (slot_wdata_o),
    .slot_rdata_i (slot_rdata_i),
    .slot_ready_i (slot_ready_i),
    .busy_o       (br_busy),
    .done_o       (br_done),
    .rdata_o      (br_rdata)
  );

  // which slot's capability / max-current word the offset hits
  always_comb begin
    cap_hit  = 1'b0;
    cap_sel  = '0;
    mcur_hit = 1'b0;
    mcur_sel = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (widx == WIDX_W'(W_CAP0 + W_STRIDE*i)) begin
        cap_hit = 1'b1;
        cap_sel = SIDX_W'(i);
      end
      if (widx == WIDX_W'(W_MCUR0 + W_STRIDE*i)) begin
        mcur_hit = 1'b1;
        mcur_sel = SIDX_W'(i);
      end
    end
  end

  always_comb begin
    if (widx == W_IRQ)  rd_val = {{(DW-NUM_SLOTS){1'b0}}, irq_stat};
    else if (cap_hit)   rd_val = cap_q[cap_sel];
    else if (mcur_hit)  rd_val = mcur_q[mcur_sel];
    else                rd_val = regs_q[widx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) regs_q[w] <= '0;
      regs_q[W_INFO] <= INFO_RESET;
      regs_q[W_DEB]  <= DEB_RESET;
    end else if (gwr && !cap_hit && !mcur_hit && widx != W_IRQ) begin
      if (widx == W_INFO) regs_q[widx] <= wdata_i & ~32'h1;
      else                regs_q[widx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        cap_q[i]  <= CAP_RESET;
        mcur_q[i] <= '0;
      end
    end else begin
      if (gwr && cap_hit)  cap_q[cap_sel]   <= wdata_i;
      if (gwr && mcur_hit) mcur_q[mcur_sel] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
    assign slot_cap_o[g*DW +: DW]     = cap_q[g];
    assign slot_maxcurr_o[g*DW +: DW] = mcur_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ack_q   <= accept && kind != ACC_SLOT;
      rdata_q <= (accept && kind == ACC_GLOBAL && !we_i) ? rd_val : '0;
      if (accept && kind == ACC_BAD) err_q <= 1'b1;
    end
  end

  assign ack_o   = ack_q | br_done;
  assign rdata_o = rdata_q | (br_done ? br_rdata : '0);
  assign err_o   = err_q;
endmodule

// File: rtl/sd_wrap_regs_chk.sv
module sd_wrap_regs_chk #(
  parameter int unsigned NUM_SLOTS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [11:0]          addr_i,
  input logic [3:0]           be_i,
  input logic                 ack_o,
  input logic [31:0]          rdata_o,
  input logic [NUM_SLOTS-1:0] slot_req_o,
  input logic [NUM_SLOTS-1:0] slot_irq_i,
  input logic                 irq_o,
  input logic                 err_o,
  input logic                 busy_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_INFO_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ack_o && $past(req_i && !busy_i && !we_i && addr_i == 12'h000 && be_i == 4'hF)
    |-> rdata_o[0] == 1'b0); // R2

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> irq_o == |$past(slot_irq_i)); // R5

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_req_o)); // R9

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |slot_req_o |=> slot_req_o == '0); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_i && addr_i[11:8] > 4'(NUM_SLOTS)
    |=> ack_o && rdata_o == 32'h0 && err_o && slot_req_o == '0); // R8

  AST_GLOBAL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_i && addr_i[11:8] == 4'h0 |=> ack_o); // R10
endmodule

bind sd_wrap_regs sd_wrap_regs_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .be_i       (be_i),
  .ack_o      (ack_o),
  .rdata_o    (rdata_o),
  .slot_req_o (slot_req_o),
  .slot_irq_i (slot_irq_i),
  .irq_o      (irq_o),
  .err_o      (err_o),
  .busy_i     (br_busy)
);

// File: tb/sd_wrap_regs_bench.sv
module sd_wrap_regs_bench;
  localparam logic [31:0] CAP = 32'h0158_30B0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic [1:0]  slot_req;
  logic        slot_we;
  logic [7:0]  slot_addr;
  logic [31:0] slot_wdata;
  logic [63:0] slot_rdata = '0;
  logic [1:0]  slot_ready = '0;
  logic [1:0]  slot_irq = '0;
  logic [63:0] slot_cap, slot_mcur;
  logic        irq, err;

  logic        o_req = 1'b0;
  logic [11:0] o_addr = '0;
  logic        o_ack, o_slot_we, o_irq, o_err;
  logic [31:0] o_rdata, o_slot_wdata, o_cap, o_mcur;
  logic [0:0]  o_slot_req;
  logic [7:0]  o_slot_addr;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sd_wrap_regs #(.NUM_SLOTS(2), .CAP_RESET(CAP)) u_sd_wrap_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .slot_req_o(slot_req), .slot_we_o(slot_we), .slot_addr_o(slot_addr),
    .slot_wdata_o(slot_wdata), .slot_rdata_i(slot_rdata),
    .slot_ready_i(slot_ready), .slot_irq_i(slot_irq), .slot_cap_o(slot_cap),
    .slot_maxcurr_o(slot_mcur), .irq_o(irq), .err_o(err)
  );

  sd_wrap_regs #(.NUM_SLOTS(1), .CAP_RESET(CAP)) u_one (
    .clk_i(clk), .rst_ni(rst_n), .req_i(o_req), .we_i(1'b0), .addr_i(o_addr),
    .be_i(4'hF), .wdata_i(32'h0), .ack_o(o_ack), .rdata_o(o_rdata),
    .slot_req_o(o_slot_req), .slot_we_o(o_slot_we), .slot_addr_o(o_slot_addr),
    .slot_wdata_o(o_slot_wdata), .slot_rdata_i(32'h0), .slot_ready_i(1'b0),
    .slot_irq_i(1'b0), .slot_cap_o(o_cap), .slot_maxcurr_o(o_mcur),
    .irq_o(o_irq), .err_o(o_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int w);
    return 32'h9E37_79B9 ^ (32'(w) * 32'h0101_0101) ^ 32'(w);
  endfunction

  // single-cycle request; samples ack/rdata in the following cycle
  task automatic bus(input logic w, input logic [11:0] a, input logic [3:0] b,
                     input logic [31:0] d, output logic [31:0] r, output logic k);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
    k = ack; r = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] r; logic k;
    bus(1'b1, a, 4'hF, d, r, k);
    check({tag, " R10 write ack"}, 32'(k), 32'd1);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] r; logic k;
    bus(1'b0, a, 4'hF, 32'h0, r, k);
    check({tag, " R10 read ack"}, 32'(k), 32'd1);
    check(tag, r, exp);
  endtask

  task automatic slot_acc(input int s, input logic w, input logic [7:0] off,
                          input logic [31:0] d, input int dly, input logic [31:0] rv);
    @(negedge clk);
    req = 1'b1; we = w; addr = 12'((s + 1) * 256) | 12'(off); be = 4'hF; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R9 strobe", 32'(slot_req), 32'(2'b01 << s));
    check("R9 local addr", 32'(slot_addr), 32'(off));
    check("R9 write flag", 32'(slot_we), 32'(w));
    if (w) check("R9 wdata", slot_wdata, d);
    check("R9 no early ack", 32'(ack), 32'd0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check("R9 strobe one cycle", 32'(slot_req), 32'd0);
      check("R9 wait for ready", 32'(ack), 32'd0);
    end
    slot_ready[s] = 1'b1;
    slot_rdata[s*32 +: 32] = rv;
    @(negedge clk);
    slot_ready = '0;
    check("R9 strobe gone", 32'(slot_req), 32'd0);
    check("R9 ack after ready", 32'(ack), 32'd1);
    if (!w) check("R9 slot rdata", rdata, rv);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; logic k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq_o", 32'(irq), 32'd0);
    check("R1 err_o", 32'(err), 32'd0);
    rd(12'h000, 32'h0003_0000, "R1 info two slots");
    rd(12'h004, 32'h0000_0005, "R1 debounce");
    rd(12'h008, 32'h0, "R1 bus");
    rd(12'h0EC, 32'h0, "R1 wp polarity");
    rd(12'h0F0, 32'h0, "R1 card detect");
    rd(12'h0FC, 32'h0, "R1 irq status");
    rd(12'h010, CAP, "R4 cap reset slot0");
    rd(12'h020, CAP, "R4 cap reset slot1");
    rd(12'h018, 32'h0, "R4 maxcurr reset");
    check("R4 cap lane reset", slot_cap[63:32], CAP);

    // one-slot build
    @(negedge clk); o_req = 1'b1; o_addr = 12'h000;
    @(negedge clk); o_req = 1'b0;
    check("R1 info one slot", o_rdata, 32'h0001_0000);
    @(negedge clk); o_req = 1'b1; o_addr = 12'h200;
    @(negedge clk); o_req = 1'b0;
    check("R8 one-slot page 0x200 ack", 32'(o_ack), 32'd1);
    check("R8 one-slot page 0x200 data", o_rdata, 32'h0);
    check("R8 one-slot no strobe", 32'(o_slot_req), 32'd0);
    check("R8 one-slot err", 32'(o_err), 32'd1);

    // R5 / R6 interrupt folding
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); slot_irq = 2'(v);
      @(negedge clk);
      check("R5 irq_o", 32'(irq), 32'(v != 0));
      rd(12'h0FC, 32'(v), "R5 status");
    end
    slot_irq = 2'b10;
    wr(12'h0FC, 32'hFFFF_FFFF, "R6");
    rd(12'h0FC, 32'h2, "R6 write ignored");
    @(negedge clk); slot_irq = 2'b00;
    @(negedge clk);
    check("R5 irq_o falls", 32'(irq), 32'd0);

    // R2 / R3 / R4 sweep of all global words
    for (int w = 0; w < 64; w++) wr(12'(w * 4), pat(w), "R3 sweep");
    for (int w = 0; w < 64; w++) begin
      if (w == 0)       rd(12'h000, pat(0) & ~32'h1, "R2 info bit0");
      else if (w == 63) rd(12'h0FC, 32'h0, "R6 status after sweep");
      else              rd(12'(w * 4), pat(w), (w == 4 || w == 6 || w == 8 || w == 10) ? "R4 readback" : "R3 readback");
    end
    check("R4 slot0 cap lane", slot_cap[31:0], pat(4));
    check("R4 slot0 maxcurr lane", slot_mcur[31:0], pat(6));
    check("R4 slot1 cap lane", slot_cap[63:32], pat(8));
    check("R4 slot1 maxcurr lane", slot_mcur[63:32], pat(10));
    check("R8 no error yet", 32'(err), 32'd0);

    // R9 slot forwarding
    slot_acc(0, 1'b0, 8'h40, 32'h0, 0, 32'hCAFE_0001);
    slot_acc(1, 1'b1, 8'hFC, 32'h1234_5678, 3, 32'h0);
    slot_acc(1, 1'b0, 8'h00, 32'h0, 1, 32'h0BAD_F00D);
    check("R9 no error", 32'(err), 32'd0);

    // R7 partial and misaligned accesses
    for (int b = 0; b < 15; b++) begin
      bus(1'b1, 12'h004, 4'(b), ~pat(1), r, k);
      check("R7 partial write ack", 32'(k), 32'd1);
    end
    rd(12'h004, pat(1), "R7 partial writes ignored");
    bus(1'b0, 12'h008, 4'h3, 32'h0, r, k);
    check("R7 partial read data", r, 32'h0);
    bus(1'b1, 12'h006, 4'hF, 32'h0, r, k);
    rd(12'h004, pat(1), "R7 misaligned write ignored");
    bus(1'b0, 12'h102, 4'hF, 32'h0, r, k);
    check("R7 misaligned slot no strobe", 32'(slot_req), 32'd0);
    check("R7 misaligned slot ack", 32'(k), 32'd1);
    check("R7 err set", 32'(err), 32'd1);

    // R8 out-of-range
    bus(1'b0, 12'h300, 4'hF, 32'h0, r, k);
    check("R8 oor read ack", 32'(k), 32'd1);
    check("R8 oor read data", r, 32'h0);
    bus(1'b1, 12'h304, 4'hF, 32'hDEAD_BEEF, r, k);
    check("R8 oor write no strobe", 32'(slot_req), 32'd0);
    rd(12'h004, pat(1), "R8 oor write ignored");
    rd(12'hF00, 32'h0, "R8 top page");
    check("R8 err sticky", 32'(err), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule